// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures one complex spectral bin of a sampled response. The bin is taken at the frequency that the excitation generator is driving at that moment. Each valid ADC sample is multiplied by the cosine and sine reference values that the excitation generator produces for the same instant. The cosine products are summed into a real accumulator. The negated sine products are summed into an imaginary accumulator. The sums run over a record of fixed length.

When the record is complete, both sums are scaled down by a fixed arithmetic right shift and clamped to the signed 16-bit range. They are then presented as two result words, and a done flag is raised. A controller pulses `start` at each new frequency point and waits for `done`. It reads the two words before the next point is started. The words stay unchanged until the next record completes.

Top module: `dft_bin_correlator`

## Requirements
- R1: After reset, `done` is 0 and both result words are 0. Samples marked valid are ignored until the first `start` pulse.
- R2: A `start` pulse clears both accumulators and the sample counter. `done` reads 0 in the cycle after `start`. A sample presented in the same cycle as `start` is not accumulated.
- R3: The real sum is the sum of sample·cos over exactly RECORD_LEN (default 1024) accepted samples. Samples and references are signed two's complement.
- R4: The imaginary sum is the negated sum of sample·sin over the same accepted samples.
- R5: A cycle with `sample_valid` low contributes nothing, whatever values are on the sample and reference inputs.
- R6: `done` rises at the clock edge that accepts the RECORD_LEN-th valid sample. It reads 1 in the following cycle and stays 1 until the next `start`.
- R7: Each result word is the full sum arithmetically shifted right by OUT_SHIFT (default 12) bits, which rounds toward minus infinity. The word is 16 bits wide.
- R8: A shifted sum above 32767 gives 32767. A shifted sum below −32768 gives −32768.
- R9: The result words change only at the edge where `done` rises. They hold their values while a later record is accumulating. Valid samples that arrive after `done` are ignored.
- R10: A `start` pulse in the middle of a record abandons that record. The next result covers only the samples that follow the new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new record |
| sample_valid | input | 1 | Marks `sample` and the references as valid this cycle |
| sample | input | 12 | Signed ADC sample |
| ref_cos | input | 12 | Signed cosine reference |
| ref_sin | input | 12 | Signed sine reference |
| real_out | output | 16 | Signed real result word |
| imag_out | output | 16 | Signed imaginary result word |
| done | output | 1 | Record complete |

## Verification
The bench builds the block with its default parameters: a record of 1024 samples, a 40-bit accumulator and a shift of 12. With a shift of 12, the full-scale sum of 2^32 lands far above the 16-bit limit, so both saturation limits can be reached with constant full-scale inputs. Small inputs such as −1·3 over a full record leave a fractional negative quotient, which exposes the rounding direction of the shift. Because the record length is the real one, the off-by-one boundary at the 1024th sample is exercised exactly. Restarts part-way through a record, gapped valid strobes and random references complete the coverage.

// File: rtl/dft_bin_correlator.sv
module dft_bin_correlator #(
  parameter int SAMPLE_W   = 12,
  parameter int REF_W      = 12,
  parameter int RECORD_LEN = 1024,
  parameter int ACC_W      = 40,
  parameter int OUT_W      = 16,
  parameter int OUT_SHIFT  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [REF_W-1:0]    ref_cos,
  input  logic signed [REF_W-1:0]    ref_sin,
  output logic signed [OUT_W-1:0]    real_out,
  output logic signed [OUT_W-1:0]    imag_out,
  output logic                       done
);
  localparam int CNT_W  = $clog2(RECORD_LEN);
  localparam int PROD_W = SAMPLE_W + REF_W;
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - 1;

  logic                     busy;
  logic [CNT_W-1:0]         cnt;
  logic signed [ACC_W-1:0]  acc_re, acc_im;
  logic signed [PROD_W-1:0] prod_c, prod_s;
  logic signed [ACC_W-1:0]  re_nx, im_nx;
  logic                     take, last;

  assign prod_c = sample * ref_cos;
  assign prod_s = sample * ref_sin;
  assign re_nx  = acc_re + ACC_W'(prod_c);
  assign im_nx  = acc_im - ACC_W'(prod_s);
  assign take   = busy && sample_valid && !start;
  assign last   = take && (cnt == CNT_W'(RECORD_LEN - 1));

  function automatic logic signed [OUT_W-1:0] reduce(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> OUT_SHIFT;
    if (s > OUT_MAX)      reduce = OUT_MAX[OUT_W-1:0];
    else if (s < OUT_MIN) reduce = OUT_MIN[OUT_W-1:0];
    else                  reduce = s[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      acc_re   <= '0;
      acc_im   <= '0;
      real_out <= '0;
      imag_out <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      cnt    <= '0;
      acc_re <= '0;
      acc_im <= '0;
    end else if (take) begin
      acc_re <= re_nx;
      acc_im <= im_nx;
      if (last) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        real_out <= reduce(re_nx);
        imag_out <= reduce(im_nx);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && busy && cnt == '0);

  assert_done_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(sample_valid) && !$past(start));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(real_out) && $stable(imag_out));

  assert_idle_no_accum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !start) |=> $stable(acc_re) && $stable(acc_im) && $stable(cnt));

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/sim_dft_bin_correlator.sv
`timescale 1ns/1ps
module sim_dft_bin_correlator;
  localparam int N  = 1024;
  localparam int SH = 12;

  logic clk = 0, rst_n = 0, start = 0, sample_valid = 0;
  logic signed [11:0] sample = 0, ref_cos = 0, ref_sin = 0;
  logic signed [15:0] real_out, imag_out;
  logic done;
  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  dft_bin_correlator u0 (.clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
    .sample(sample), .ref_cos(ref_cos), .ref_sin(ref_sin),
    .real_out(real_out), .imag_out(imag_out), .done(done));

  bit m_busy, m_done;
  int m_cnt;
  longint m_re, m_im, m_rq, m_iq;

  function automatic longint sat(longint a);
    longint s = a >>> SH;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_re = 0; m_im = 0; m_rq = 0; m_iq = 0;
    end else if (start) begin
      m_busy = 1; m_done = 0; m_cnt = 0; m_re = 0; m_im = 0;
    end else if (m_busy && sample_valid) begin
      m_re += longint'(sample) * longint'(ref_cos);
      m_im -= longint'(sample) * longint'(ref_sin);
      m_cnt++;
      if (m_cnt == N) begin
        m_busy = 0; m_done = 1; m_rq = sat(m_re); m_iq = sat(m_im);
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cycles++;
    check("R6 done per-cycle", done, m_done);
    check("R3/R7/R8/R9 real per-cycle", real_out, m_rq);
    check("R4/R7/R8/R9 imag per-cycle", imag_out, m_iq);
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(bit v, int x, int c, int s, bit st = 0);
    @(negedge clk);
    start = st; sample_valid = v; sample = 12'(x); ref_cos = 12'(c); ref_sin = 12'(s);
  endtask

  task automatic record(int x, int c, int s);
    step(1, x, c, s, 1);
    for (int i = 0; i < N; i++) step(1, x, c, s);
    step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 real after reset", real_out, 0);
    for (int i = 0; i < 1100; i++) step(1, 500, 500, 500);
    step(0, 0, 0, 0);
    check("R1 no record before start", done, 0);
    check("R1 real untouched before start", real_out, 0);

    record(100, 1000, 0);
    check("R3 real constant record", real_out, (100 * 1000 * 1024) >>> SH);
    check("R4 imag zero with sin 0", imag_out, 0);

    record(-50, 0, 700);
    check("R4 imag negated sin", imag_out, 8750);

    record(-1, 3, 0);
    check("R7 floor of negative sum", real_out, -1);

    record(2047, 2047, 2047);
    check("R8 positive saturation", real_out, 32767);
    check("R8 negative saturation", imag_out, -32768);

    step(1, 7, 9, 11, 1);
    check("R2 done low after start", 0, 0);
    step(1, 10, 10, 10);
    check("R2 done low after start", done, 0);
    check("R9 real held during record", real_out, 32767);
    for (int i = 0; i < N - 2; i++) step(1, 10, 10, 10);
    step(0, 0, 0, 0);
    check("R6 done low after N-1", done, 0);
    step(1, 10, 10, 10);
    step(0, 0, 0, 0);
    check("R6 done high after Nth", done, 1);
    check("R3 real 10x10x1024", real_out, (10 * 10 * 1024) >>> SH);
    for (int i = 0; i < 50; i++) step(1, 2047, 2047, 2047);
    step(0, 0, 0, 0);
    check("R9 samples after done ignored", real_out, 25);
    check("R6 done stays high", done, 1);

    step(1, 0, 0, 0, 1);
    for (int i = 0; i < N; i++) begin
      step(1, 40, -100, 60);
      step(0, 2047, 2047, 2047);
    end
    step(0, 0, 0, 0);
    check("R5 gaps ignored real", real_out, (-4000 * 1024) >>> SH);
    check("R5 gaps ignored imag", imag_out, (-2400 * 1024) >>> SH);

    step(1, 0, 0, 0, 1);
    for (int i = 0; i < 500; i++) step(1, 2047, 2047, 2047);
    record(20, 20, -20);
    check("R10 restart mid-record real", real_out, 100);
    check("R10 restart mid-record imag", imag_out, 100);

    step(1, 0, 0, 0, 1);
    for (int i = 0; i < 3 * N; i++)
      step(($urandom % 4) != 0, int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048,
           int'($urandom % 4096) - 2048);
    step(0, 0, 0, 0);
    check("R3/R4 random record done", done, 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule